// File: doc/BRIEF.md
# Page Write Buffer and Timed Programming Engine

This block sits behind the serial command decoder of a small serial-access nonvolatile memory. During a write transaction it collects data bytes into a 16-entry page buffer. A write pointer advances through the low four address bits and stays inside the page named by the start address. When chip select rises, the block decides whether the transaction qualifies for programming. It qualifies only if the transaction ended on a byte boundary, at least one data byte arrived, and the external protection logic allows the write. If so, the block runs a self-timed programming cycle.

During that cycle the block holds its busy output high. The decoder returns busy as the ready bit of the status byte. In the first cycles of programming, the block presents each buffered byte on the array write port, one per cycle. The whole cycle lasts a fixed, parameterised number of clock cycles. When it ends, busy falls and a one-cycle pulse tells the decoder to clear its write-enable latch. While busy is high, the block ignores all transaction inputs.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, busy, arr_we and wel_clr are all 0.
- R2: A wr_start pulse fixes the page as start_addr[ADDR_W-1:4] and the buffer pointer as start_addr[3:0]. Each byte_vld pulse stores byte_dat at the pointer, then increments only the 4-bit pointer, so the page bits never change.
- R3: When the pointer passes index 15 it wraps to index 0 of the same page. A later byte at an index overwrites the earlier byte at that index, and only the last value is programmed.
- R4: A cs_rise launches programming only when byte_aligned is 1. When cs_rise arrives with byte_aligned 0, the buffered bytes are discarded, busy stays 0 and nothing is written.
- R5: A cs_rise with no data byte received since wr_start starts no cycle and writes nothing.
- R6: A cs_rise while allow is 0 starts no cycle, writes nothing, and discards the buffered bytes.
- R7: On a qualifying cs_rise, busy is 1 from the next cycle for exactly CYCLE_CNT cycles.
- R8: During programming, arr_we is 1 exactly once for each buffer index written in the transaction, and never for any other index. The writes come in ascending index order within the first 16 busy cycles, with arr_addr = {page, index} and arr_wdata = that buffered byte.
- R9: wel_clr is 1 for exactly the one cycle in which busy has just fallen, and 0 at all other times.
- R10: While busy is 1, wr_start, byte_vld and cs_rise have no effect. Bytes offered then are neither programmed nor kept, and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write transaction start strobe; loads start_addr |
| start_addr | input | ADDR_W | First byte address of the transaction |
| byte_vld | input | 1 | One data byte received |
| byte_dat | input | 8 | Received data byte |
| byte_aligned | input | 1 | Serial bit count is a whole number of bytes |
| cs_rise | input | 1 | Chip select has just been released |
| allow | input | 1 | Protection logic permits writing this page |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
Busy is registered, so it reads 1 in the first sample after the edge that captured a qualifying cs_rise. It then stays 1 for CYCLE_CNT samples. wel_clr appears in the same sample in which busy first reads 0. Array writes start in that first busy sample and arrive one per cycle, in ascending index order, over the next 16 samples. The driver computes the expected writes from its own page model and puts them in a queue when it releases chip select. A monitor samples on the falling clock edge and pops one queue entry for each arr_we it sees. The driver counts busy samples and then checks wel_clr at the falling edge and again one sample later.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } ppe_phase_e;
endpackage

// File: rtl/ppe_page_buf.sv
module ppe_page_buf #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_dat,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_dat,
    output logic              rd_vld,
    output logic              any_vld
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DEPTH-1:0]  vld_q, vld_d;

    always_comb begin
        mem_d = mem_q;
        vld_d = vld_q;
        if (clr) begin
            vld_d = '0;
        end else if (wr_en) begin
            mem_d[wr_idx] = wr_dat;
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            mem_q[g] <= mem_d[g];
        end
    end

    assign rd_dat  = mem_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign any_vld = |vld_q;
endmodule

// File: rtl/ppe_cycle_timer.sv
module ppe_cycle_timer #(
    parameter int CYCLE_CNT = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYCLE_CNT + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t s_q, s_d;

    assign done = s_q.run && (s_q.cnt == CW'(CYCLE_CNT - 1));

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
        end else if (done) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (s_q.run) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
    parameter int ADDR_W    = 9,
    parameter int IDX_W     = 4,
    parameter int CYCLE_CNT = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    input  logic              byte_aligned,
    input  logic              cs_rise,
    input  logic              allow,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              busy,
    output logic              wel_clr
);
    import ppe_pkg::*;

    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam int DEPTH  = 1 << IDX_W;

    typedef struct packed {
        ppe_phase_e        phase;
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  ptr;
        logic [IDX_W:0]    idx;
        logic              busy;
        logic              wel_clr;
    } eng_state_t;

    eng_state_t s_q, s_d;

    logic       idle, launch, buf_clr, buf_we, tmr_done;
    logic       rd_vld, any_vld;
    logic [7:0] rd_dat;

    assign idle    = (s_q.phase == PH_IDLE);
    assign launch  = idle && cs_rise && byte_aligned && allow && any_vld;
    assign buf_we  = idle && byte_vld && !wr_start && !cs_rise;
    assign buf_clr = (idle && (wr_start || (cs_rise && !launch))) || tmr_done;

    ppe_page_buf #(.IDX_W(IDX_W), .DATA_W(8)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_we),
        .wr_idx  (s_q.ptr),
        .wr_dat  (byte_dat),
        .rd_idx  (s_q.idx[IDX_W-1:0]),
        .rd_dat  (rd_dat),
        .rd_vld  (rd_vld),
        .any_vld (any_vld)
    );

    ppe_cycle_timer #(.CYCLE_CNT(CYCLE_CNT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch),
        .done  (tmr_done)
    );

    always_comb begin
        s_d         = s_q;
        s_d.wel_clr = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (wr_start) begin
                    s_d.page = start_addr[ADDR_W-1:IDX_W];
                    s_d.ptr  = start_addr[IDX_W-1:0];
                end else if (buf_we) begin
                    s_d.ptr = s_q.ptr + 1'b1;
                end
                if (launch) begin
                    s_d.phase = PH_PROG;
                    s_d.idx   = '0;
                    s_d.busy  = 1'b1;
                end
            end
            PH_PROG: begin
                if (s_q.idx != (IDX_W+1)'(DEPTH)) s_d.idx = s_q.idx + 1'b1;
                if (tmr_done) begin
                    s_d.phase   = PH_IDLE;
                    s_d.busy    = 1'b0;
                    s_d.wel_clr = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arr_we    = (s_q.phase == PH_PROG) && !s_q.idx[IDX_W] && rd_vld;
    assign arr_addr  = {s_q.page, s_q.idx[IDX_W-1:0]};
    assign arr_wdata = rd_dat;
    assign busy      = s_q.busy;
    assign wel_clr   = s_q.wel_clr;
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker #(
    parameter int ADDR_W    = 9,
    parameter int IDX_W     = 4,
    parameter int CYCLE_CNT = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              byte_aligned,
    input logic              allow,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              busy,
    input logic              wel_clr
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R4
    rise_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise) && $past(byte_aligned));

    // R6
    rise_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(allow));

    // R7
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == CYCLE_CNT);

    // R8
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R8
    write_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) |->
            arr_addr[IDX_W-1:0] > $past(arr_addr[IDX_W-1:0]));

    // R9
    wel_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> wel_clr);

    // R9
    wel_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> !busy && $past(busy));
endmodule

bind page_prog_engine ppe_checker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CYCLE_CNT(CYCLE_CNT)
) u_ppe_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_rise      (cs_rise),
    .byte_aligned (byte_aligned),
    .allow        (allow),
    .arr_we       (arr_we),
    .arr_addr     (arr_addr),
    .busy         (busy),
    .wel_clr      (wel_clr)
);

// File: tb/page_prog_engine_bench.sv
`timescale 1ns/1ps
module page_prog_engine_bench;
    localparam int AW = 9;
    localparam int CC = 48;
    localparam int PB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_dat = '0;
    logic          byte_aligned = 1'b0;
    logic          cs_rise = 1'b0;
    logic          allow = 1'b0;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;
    logic          busy;
    logic          wel_clr;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [AW+7:0] expq[$];
    logic [7:0]    m_buf [PB];
    bit            m_vld [PB];
    int            m_page, m_ptr;

    always #2.5 clk = ~clk;

    page_prog_engine #(.ADDR_W(AW), .IDX_W(4), .CYCLE_CNT(CC)) u_page_prog_engine (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_aligned(byte_aligned),
        .cs_rise(cs_rise), .allow(allow), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .busy(busy), .wel_clr(wel_clr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every array write must match the next expected item (R8)
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8", "unexpected array write addr", int'(arr_addr), -1);
            end else begin
                logic [AW+7:0] e;
                e = expq.pop_front();
                chk({arr_addr, arr_wdata} == e, "R8", "array write {addr,data}",
                    int'({arr_addr, arr_wdata}), int'(e));
            end
        end
    end

    task automatic start_tx(input int addr);
        @(negedge clk);
        wr_start   = 1'b1;
        start_addr = AW'(addr);
        @(negedge clk);
        wr_start = 1'b0;
        m_page = addr >> 4;
        m_ptr  = addr & 15;
        for (int i = 0; i < PB; i++) m_vld[i] = 0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_vld = 1'b1;
        byte_dat = d;
        @(negedge clk);
        byte_vld = 1'b0;
        m_buf[m_ptr] = d;
        m_vld[m_ptr] = 1;
        m_ptr = (m_ptr + 1) % PB;
    endtask

    task automatic end_tx(input bit aligned, input bit alw, input bit noise,
                          input string req);
        bit any;
        bit go;
        int n;
        any = 0;
        for (int i = 0; i < PB; i++) any |= m_vld[i];
        go = aligned && alw && any;
        if (go)
            for (int i = 0; i < PB; i++)
                if (m_vld[i]) expq.push_back({AW'((m_page << 4) | i), m_buf[i]});
        for (int i = 0; i < PB; i++) m_vld[i] = 0;
        cs_rise      = 1'b1;
        byte_aligned = aligned;
        allow        = alw;
        @(negedge clk);
        cs_rise = 1'b0;
        chk(busy == go, req, "busy after release", busy, go);
        if (go) begin
            n = 0;
            while (busy && n < CC + 10) begin
                n++;
                if (noise && n < 20) begin
                    // R10: traffic offered while programming
                    byte_vld   = 1'b1;
                    byte_dat   = 8'(8'hE0 + n);
                    wr_start   = (n == 3);
                    start_addr = 9'h0F0;
                    cs_rise    = (n == 6);
                    byte_aligned = 1'b1;
                    allow      = 1'b1;
                end
                @(negedge clk);
                byte_vld = 1'b0;
                wr_start = 1'b0;
                cs_rise  = 1'b0;
            end
            chk(n == CC, "R7", "busy cycle count", n, CC);
            chk(wel_clr == 1'b1, "R9", "wel_clr when busy falls", wel_clr, 1);
            @(negedge clk);
            chk(wel_clr == 1'b0, "R9", "wel_clr one cycle later", wel_clr, 0);
            chk(busy == 1'b0, noise ? "R10" : "R7", "no second cycle", busy, 0);
            chk(expq.size() == 0, "R8", "pending writes", expq.size(), 0);
        end else begin
            bit seen;
            seen = 0;
            repeat (CC + 4) begin
                if (busy || wel_clr) seen = 1;
                @(negedge clk);
            end
            chk(!seen, req, "no cycle started", seen, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(arr_we == 1'b0, "R1", "arr_we in reset", arr_we, 0);
        chk(wel_clr == 1'b0, "R1", "wel_clr in reset", wel_clr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: single byte
        start_tx(9'h123);
        send_byte(8'h5A);
        end_tx(1, 1, 0, "R2");

        // R2: several bytes, page fixed
        start_tx(9'h0A0);
        for (int i = 0; i < 5; i++) send_byte(8'(8'h10 + i));
        end_tx(1, 1, 0, "R2");

        // R3: wrap past index 15 and overwrite
        start_tx(9'h1FC);
        for (int i = 0; i < 20; i++) send_byte(8'(8'h80 + i));
        end_tx(1, 1, 0, "R3");

        // R4: release mid-byte
        start_tx(9'h040);
        send_byte(8'hC3);
        end_tx(0, 1, 0, "R4");
        // R4: discarded bytes not carried into a later release
        end_tx(1, 1, 0, "R4");

        // R5: no data byte
        start_tx(9'h060);
        end_tx(1, 1, 0, "R5");

        // R6: protection refuses
        start_tx(9'h070);
        send_byte(8'h77);
        end_tx(1, 0, 0, "R6");
        end_tx(1, 1, 0, "R6");

        // R10: traffic during programming ignored
        start_tx(9'h135);
        send_byte(8'h3C);
        send_byte(8'h4D);
        end_tx(1, 1, 1, "R10");
        end_tx(1, 1, 0, "R10");

        // R8: sparse indices after wrap
        start_tx(9'h02E);
        for (int i = 0; i < 4; i++) send_byte(8'(8'hA0 + i));
        end_tx(1, 1, 0, "R8");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule